// File: doc/BRIEF.md
# Parallel CRC Next-State Function

This block computes the next value of a CRC register after a whole data word of any width has been absorbed, all in one combinational step. It takes the present register contents and a data word and returns the updated register. It holds no state and has no clock. The polynomial, the register width, the word width and the bit ordering are fixed when the block is elaborated.

Each output bit is a fixed XOR of some register bits and some data bits. That set is found at elaboration by running the one-bit-at-a-time shift-register rule once for each input bit, with only that bit set, over as many steps as the word has bits.

The surrounding logic owns the register itself. It loads the start value before the first word, feeds each output back as the next register input, and XORs the last output with the final mask to get the checksum. Two orderings are offered:
- **LSB-first (reflected):** data bit 0 enters first and the register is kept bit-reversed.
- **MSB-first (normal):** the top data bit enters first and the register shifts left.

Top module: `crc_par_update`

## Requirements
- R1: The block is purely combinational. Its output follows every change of `data_in` or `crc_in` with no clock edge in between, and it has exactly three ports.
- R2: In LSB-first order the register is kept bit-reversed and data bit 0 enters first. With the 32-bit polynomial 0x04C11DB7 and start value 0xFFFFFFFF, the ASCII bytes "123456789" are applied one per word. The last output XOR 0xFFFFFFFF must equal 0xCBF43926.
- R3: In MSB-first order the top data bit enters first and the register shifts left. With the same polynomial and start value, the final mask 0, and the same bytes, the result is 0x0376E6E7.
- R4: With `crc_in` all zero and `data_in` all zero, `crc_out` is all zero, for every parameter set.
- R5: A word width that is not a multiple of 8 works. With a 12-bit register, polynomial 0x80F, MSB-first and 5-bit words, every step matches the serial rule.
- R6: A 32-bit word in LSB-first order takes its lowest byte first. Two words packed from "12345678" ({byte3,byte2,byte1,byte0} per word) give the same register as eight 8-bit steps over the same bytes.
- R7: 16-bit registers work in both orderings. Polynomial 0x8005, LSB-first, start value 0, mask 0 gives 0xBB3D for "123456789". Polynomial 0x1021, MSB-first, start value 0, mask 0 gives 0x31C3.
- R8: An 8-bit register with polynomial 0x07, MSB-first, start value 0 and mask 0 gives 0xF4 for "123456789".
- R9: A 64-bit register with polynomial 0x1B, LSB-first, start value all ones and mask all ones gives 0xB90956C775A41001 for "123456789".
- R10: For arbitrary register values and data words, every single step equals D iterations of the bit-serial rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | DATA_W | Data word absorbed in this step |
| crc_in | input | CRC_W | Present register value (start value or previous output) |
| crc_out | output | CRC_W | Register value after the word is absorbed |

## Verification
The hardest case to reach from the ports is a mismatch between word widths. A fault in how bits are ordered inside a wide word can still leave each narrow check value correct. The stimulus therefore drives a 32-bit instance and an 8-bit instance with the same bytes and requires both to end in the same register state. A 5-bit instance is added, whose words straddle byte boundaries. Every step of every instance is also compared against a bit-serial queue model, both from catalogue start values and from pseudo-random register contents. This reaches register states that a single check string never produces.

// File: rtl/crc_par_pkg.sv
`timescale 1ns/1ps
package crc_par_pkg;

    typedef enum bit {
        ORDER_MSB_FIRST = 1'b0,
        ORDER_LSB_FIRST = 1'b1
    } bit_order_e;

    localparam int MAX_CRC_W = 64;

    function automatic logic [MAX_CRC_W-1:0] width_mask(input int w);
        logic [MAX_CRC_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_CRC_W; i++) begin
            if (i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [MAX_CRC_W-1:0] mirror(input logic [MAX_CRC_W-1:0] v, input int w);
        logic [MAX_CRC_W-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_CRC_W; i++) begin
            if (i < w) r[i] = v[w-1-i];
        end
        return r;
    endfunction

    // Response of the serial rule to one set input bit: either a register
    // bit given in seed (data_bit < 0) or data bit data_bit with seed zero.
    function automatic logic [MAX_CRC_W-1:0] impulse(
        input logic [MAX_CRC_W-1:0] seed,
        input int                   w,
        input logic [MAX_CRC_W-1:0] poly,
        input bit_order_e           order,
        input int                   d,
        input int                   data_bit
    );
        logic [MAX_CRC_W-1:0] r;
        logic [MAX_CRC_W-1:0] m;
        logic [MAX_CRC_W-1:0] rp;
        logic                 fb;
        logic                 din;
        int                   idx;
        m  = width_mask(w);
        rp = mirror(poly, w);
        r  = seed & m;
        for (int k = 0; k < d; k++) begin
            idx = (order == ORDER_LSB_FIRST) ? k : d - 1 - k;
            din = (idx == data_bit);
            if (order == ORDER_LSB_FIRST) begin
                fb = r[0] ^ din;
                r  = r >> 1;
                if (fb) r = r ^ rp;
            end else begin
                fb = r[w-1] ^ din;
                r  = (r << 1) & m;
                if (fb) r = r ^ (poly & m);
            end
        end
        return r & m;
    endfunction

endpackage

// File: rtl/crc_par_state_fold.sv
`timescale 1ns/1ps
module crc_par_state_fold #(
    parameter int                     CRC_W = 32,
    parameter int                     DATA_W = 8,
    parameter logic [63:0]            POLY = 64'h04C11DB7,
    parameter crc_par_pkg::bit_order_e ORDER = crc_par_pkg::ORDER_LSB_FIRST
) (
    input  logic [CRC_W-1:0] crc_in,
    output logic [CRC_W-1:0] state_part
);
    logic [CRC_W-1:0] col_term [CRC_W];

    for (genvar j = 0; j < CRC_W; j++) begin : g_col
        localparam logic [63:0] COL =
            crc_par_pkg::impulse(64'd1 << j, CRC_W, POLY, ORDER, DATA_W, -1);
        assign col_term[j] = COL[CRC_W-1:0] & {CRC_W{crc_in[j]}};
    end

    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = '0;
        for (int j = 0; j < CRC_W; j++) acc = acc ^ col_term[j];
        state_part = acc;
        // R4: a zero register contributes nothing
        if (crc_in == '0)
            a_r4_state_zero: assert (state_part == '0)
                else $error("state contribution nonzero for zero register");
    end
endmodule

// File: rtl/crc_par_data_fold.sv
`timescale 1ns/1ps
module crc_par_data_fold #(
    parameter int                     CRC_W = 32,
    parameter int                     DATA_W = 8,
    parameter logic [63:0]            POLY = 64'h04C11DB7,
    parameter crc_par_pkg::bit_order_e ORDER = crc_par_pkg::ORDER_LSB_FIRST
) (
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  data_part
);
    logic [CRC_W-1:0] col_term [DATA_W];

    for (genvar j = 0; j < DATA_W; j++) begin : g_col
        localparam logic [63:0] COL =
            crc_par_pkg::impulse(64'd0, CRC_W, POLY, ORDER, DATA_W, j);
        assign col_term[j] = COL[CRC_W-1:0] & {CRC_W{data_in[j]}};
    end

    always_comb begin
        logic [CRC_W-1:0] acc;
        acc = '0;
        for (int j = 0; j < DATA_W; j++) acc = acc ^ col_term[j];
        data_part = acc;
        // R4: a zero word contributes nothing
        if (data_in == '0)
            a_r4_data_zero: assert (data_part == '0)
                else $error("data contribution nonzero for zero word");
    end
endmodule

// File: rtl/crc_par_update.sv
`timescale 1ns/1ps
module crc_par_update #(
    parameter int                     CRC_W = 32,
    parameter int                     DATA_W = 8,
    parameter logic [63:0]            POLY = 64'h04C11DB7,
    parameter crc_par_pkg::bit_order_e ORDER = crc_par_pkg::ORDER_LSB_FIRST
) (
    input  logic [DATA_W-1:0] data_in,
    input  logic [CRC_W-1:0]  crc_in,
    output logic [CRC_W-1:0]  crc_out
);
    logic [CRC_W-1:0] state_part;
    logic [CRC_W-1:0] data_part;

    crc_par_state_fold #(
        .CRC_W (CRC_W),
        .DATA_W(DATA_W),
        .POLY  (POLY),
        .ORDER (ORDER)
    ) u_state (
        .crc_in    (crc_in),
        .state_part(state_part)
    );

    crc_par_data_fold #(
        .CRC_W (CRC_W),
        .DATA_W(DATA_W),
        .POLY  (POLY),
        .ORDER (ORDER)
    ) u_data (
        .data_in  (data_in),
        .data_part(data_part)
    );

    always_comb begin
        crc_out = state_part ^ data_part;
        // R1: known inputs never yield an unknown output
        if (!$isunknown({data_in, crc_in}))
            a_r1_known_out: assert (!$isunknown(crc_out))
                else $error("unknown output for known inputs");
        // R4: all-zero inputs map to an all-zero register
        if (crc_in == '0 && data_in == '0)
            a_r4_zero_maps_zero: assert (crc_out == '0)
                else $error("zero inputs gave nonzero register");
    end
endmodule

// File: tb/crc_par_update_test.sv
`timescale 1ns/1ps
module crc_par_update_test;
    import crc_par_pkg::*;

    localparam int NI = 8;
    localparam int          W_T [NI] = '{32, 32, 32, 16, 16, 8, 12, 64};
    localparam int          D_T [NI] = '{8, 8, 32, 8, 8, 8, 5, 8};
    localparam logic [63:0] P_T [NI] = '{64'h04C11DB7, 64'h04C11DB7, 64'h04C11DB7,
                                         64'h8005, 64'h1021, 64'h07, 64'h80F, 64'h1B};
    localparam bit          L_T [NI] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [63:0] din  [NI];
    logic [63:0] cin  [NI];
    logic [63:0] cout [NI];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [63:0] rng = 64'h9E3779B97F4A7C15;

    wire [31:0] o0, o1, o2;
    wire [15:0] o3, o4;
    wire [7:0]  o5;
    wire [11:0] o6;
    wire [63:0] o7;
    assign cout[0] = {32'd0, o0};
    assign cout[1] = {32'd0, o1};
    assign cout[2] = {32'd0, o2};
    assign cout[3] = {48'd0, o3};
    assign cout[4] = {48'd0, o4};
    assign cout[5] = {56'd0, o5};
    assign cout[6] = {52'd0, o6};
    assign cout[7] = o7;

    crc_par_update #(.CRC_W(32), .DATA_W(8), .POLY(64'h04C11DB7), .ORDER(ORDER_LSB_FIRST))
        uut (.data_in(din[0][7:0]), .crc_in(cin[0][31:0]), .crc_out(o0));
    crc_par_update #(.CRC_W(32), .DATA_W(8), .POLY(64'h04C11DB7), .ORDER(ORDER_MSB_FIRST))
        uut_n32 (.data_in(din[1][7:0]), .crc_in(cin[1][31:0]), .crc_out(o1));
    crc_par_update #(.CRC_W(32), .DATA_W(32), .POLY(64'h04C11DB7), .ORDER(ORDER_LSB_FIRST))
        uut_w32 (.data_in(din[2][31:0]), .crc_in(cin[2][31:0]), .crc_out(o2));
    crc_par_update #(.CRC_W(16), .DATA_W(8), .POLY(64'h8005), .ORDER(ORDER_LSB_FIRST))
        uut_arc (.data_in(din[3][7:0]), .crc_in(cin[3][15:0]), .crc_out(o3));
    crc_par_update #(.CRC_W(16), .DATA_W(8), .POLY(64'h1021), .ORDER(ORDER_MSB_FIRST))
        uut_xm (.data_in(din[4][7:0]), .crc_in(cin[4][15:0]), .crc_out(o4));
    crc_par_update #(.CRC_W(8), .DATA_W(8), .POLY(64'h07), .ORDER(ORDER_MSB_FIRST))
        uut_c8 (.data_in(din[5][7:0]), .crc_in(cin[5][7:0]), .crc_out(o5));
    crc_par_update #(.CRC_W(12), .DATA_W(5), .POLY(64'h80F), .ORDER(ORDER_MSB_FIRST))
        uut_odd (.data_in(din[6][4:0]), .crc_in(cin[6][11:0]), .crc_out(o6));
    crc_par_update #(.CRC_W(64), .DATA_W(8), .POLY(64'h1B), .ORDER(ORDER_LSB_FIRST))
        uut_g64 (.data_in(din[7][7:0]), .crc_in(cin[7][63:0]), .crc_out(o7));

    function automatic logic [63:0] mask_of(int k);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < W_T[k]; i++) m[i] = 1'b1;
        return m;
    endfunction

    // Bit-serial model: data bits queued in arrival order, one shift each.
    function automatic logic [63:0] model_step(int k, logic [63:0] c, logic [63:0] d);
        bit q[$];
        logic [63:0] m, rp, r;
        bit b, top;
        int w;
        w = W_T[k];
        m = mask_of(k);
        rp = '0;
        for (int i = 0; i < w; i++) rp[i] = P_T[k][w-1-i];
        for (int i = 0; i < D_T[k]; i++) q.push_back(L_T[k] ? d[i] : d[D_T[k]-1-i]);
        r = c & m;
        while (q.size() > 0) begin
            b = q.pop_front();
            if (L_T[k]) begin
                top = r[0] ^ b;
                r = r >> 1;
                if (top) r ^= rp;
            end else begin
                top = r[w-1] ^ b;
                r = (r << 1) & m;
                if (top) r ^= P_T[k] & m;
            end
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    // One step of instance k; register follows the model to stay aligned.
    task automatic step(int k, logic [63:0] d, string req);
        logic [63:0] exp;
        @(negedge clk);
        din[k] = d;
        #1;
        exp = model_step(k, cin[k], d);
        check(req, cout[k] & mask_of(k), exp);
        cin[k] = exp;
    endtask

    task automatic feed_bytes(int k, string s, logic [63:0] init, string req);
        cin[k] = init;
        for (int i = 0; i < s.len(); i++) step(k, {56'd0, s[i]}, req);
    endtask

    initial begin
        for (int k = 0; k < NI; k++) begin
            din[k] = '0;
            cin[k] = '0;
        end
        repeat (2) @(posedge clk);

        // R4: zero in, zero out, on every instance
        @(negedge clk);
        #1;
        for (int k = 0; k < NI; k++) check("R4", cout[k] & mask_of(k), 64'd0);

        // R1: output tracks two input changes with no clock edge between
        @(negedge clk);
        cin[0] = 64'h12345678;
        din[0] = 64'hA5;
        #0.5;
        check("R1", cout[0] & mask_of(0), model_step(0, 64'h12345678, 64'hA5));
        din[0] = 64'h3C;
        #0.5;
        check("R1", cout[0] & mask_of(0), model_step(0, 64'h12345678, 64'h3C));

        // R2: LSB-first 32-bit check string
        feed_bytes(0, "123456789", 64'hFFFFFFFF, "R2");
        check("R2", (cin[0] ^ 64'hFFFFFFFF) & mask_of(0), 64'hCBF43926);

        // R3: MSB-first 32-bit check string
        feed_bytes(1, "123456789", 64'hFFFFFFFF, "R3");
        check("R3", cin[1], 64'h0376E6E7);

        // R7: both 16-bit orderings
        feed_bytes(3, "123456789", 64'h0, "R7");
        check("R7", cin[3], 64'hBB3D);
        feed_bytes(4, "123456789", 64'h0, "R7");
        check("R7", cin[4], 64'h31C3);

        // R8: 8-bit register
        feed_bytes(5, "123456789", 64'h0, "R8");
        check("R8", cin[5], 64'hF4);

        // R9: 64-bit register
        feed_bytes(7, "123456789", 64'hFFFFFFFFFFFFFFFF, "R9");
        check("R9", cin[7] ^ 64'hFFFFFFFFFFFFFFFF, 64'hB90956C775A41001);

        // R6: 32-bit words, lowest byte first, match eight byte steps
        feed_bytes(0, "12345678", 64'hFFFFFFFF, "R6");
        cin[2] = 64'hFFFFFFFF;
        step(2, 64'h34333231, "R6");
        step(2, 64'h38373635, "R6");
        check("R6", cin[2], cin[0]);

        // R5: 5-bit words on a 12-bit register, edge patterns then random
        cin[6] = 64'hFFF;
        step(6, 64'h1F, "R5");
        step(6, 64'h10, "R5");
        step(6, 64'h01, "R5");
        step(6, 64'h00, "R5");
        for (int i = 0; i < 40; i++) step(6, next_rand() & 64'h1F, "R5");

        // R10: random register values and words on every instance
        for (int k = 0; k < NI; k++) begin
            for (int i = 0; i < 30; i++) begin
                cin[k] = next_rand() & mask_of(k);
                step(k, next_rand(), "R10");
            end
        end

        // R10: single-bit words from a zero register, one per data position
        for (int k = 0; k < NI; k++) begin
            for (int j = 0; j < D_T[k]; j++) begin
                cin[k] = '0;
                step(k, 64'd1 << j, "R10");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule